// File: doc/BRIEF.md
# Chip Erase Sequencer

This controller runs a full chip erase of a byte-wide parallel flash device from the host side. A pulse on `start` begins a run. The controller first asks an external agent to program every byte to 00H, using a request/acknowledge handshake. It then alternates erase pulses with byte-by-byte verification. An erase pulse is two consecutive command writes of 20H followed by a long settle wait. A verification is a write of A0H carrying the address under test, a short wait, one read cycle, and a compare against FFH.

A byte that reads FFH moves the run to the next address, and the next address is verified with no new pulse. A byte that does not read FFH counts one failed pulse and triggers another erase pulse. After that pulse, verification resumes at the same address, not at address zero. One failure counter covers the whole run. When it reaches `MAX_PULSES`, the run stops with `error`. When the last address passes, a 00H write returns the device to read mode and `done` is raised. Both wait lengths are parameters given in clock cycles.

The states are:
- IDLE
- PREP: waiting for the acknowledge of the pre-program pass
- SETUP and CONFIRM: the two 20H writes
- PWAIT: the pulse wait
- VCMD: the A0H write
- VWAIT: the verify wait
- VREAD: the read cycle
- VCMP: the compare
- RESTORE: the 00H write
- DONE and FAIL

The transitions are:
- IDLE, DONE or FAIL go to PREP on `start`.
- PREP goes to SETUP on `pre_ack`.
- SETUP goes to CONFIRM, and CONFIRM goes to PWAIT.
- PWAIT goes to VCMD when its timer expires.
- VCMD goes to VWAIT.
- VWAIT goes to VREAD when its timer expires.
- VREAD goes to VCMP.
- VCMP goes to VCMD (byte passed, more addresses), RESTORE (last byte passed), SETUP (byte failed, retries remain) or FAIL (limit reached).
- RESTORE goes to DONE.

Top module: `chip_erase_seq`

## Requirements
- R1: During and right after reset, `pre_req`, `bus_we`, `bus_re`, `done` and `error` are all low.
- R2: A `start` sampled in IDLE, DONE or FAIL raises `pre_req` in the next cycle. `pre_req` stays high, with no bus write or read, until `pre_ack` is sampled high.
- R3: An erase pulse is two consecutive write cycles with `bus_wdata` = 20H, followed by exactly `PULSE_WAIT` cycles with no bus activity.
- R4: A verification is one write cycle with `bus_wdata` = A0H and `bus_addr` = the address under test, then `VERIFY_WAIT` idle cycles, then one `bus_re` cycle at the same address. `bus_rdata` is sampled in the single idle cycle that follows the read.
- R5: Each run starts with address 0 and a failure count of 0. The first erase pulse comes right after the acknowledge.
- R6: If the sampled byte equals FFH and it is not the last address, the verify write for the next address follows in the very next cycle, with no erase pulse in between.
- R7: If the sampled byte differs from FFH and the limit is not reached, the next cycle starts a new erase pulse. Verification then resumes at the same address.
- R8: When the `MAX_PULSES`-th failed compare of a run occurs, `error` rises in the next cycle and no further bus activity takes place.
- R9: When the last address (all ones) passes, a single write of 00H follows in the next cycle, and `done` rises the cycle after that.
- R10: `done` and `error` are never high together. Each holds until a new `start`. A `start` sampled in any other state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chip erase run |
| pre_req | output | 1 | Request for the pre-program pass (all bytes to 00H) |
| pre_ack | input | 1 | Pre-program pass finished |
| bus_we | output | 1 | Write strobe, one cycle per command write |
| bus_re | output | 1 | Read strobe, one cycle per verify read |
| bus_addr | output | ADDR_W | Address under test |
| bus_wdata | output | 8 | Command byte during a write |
| bus_rdata | input | 8 | Byte returned by the device, valid the cycle after `bus_re` |
| done | output | 1 | Erase completed |
| error | output | 1 | Pulse limit reached |

## Verification
Each run uses a flash model in which every byte needs its own number of erase pulses before it reads FFH.

- A uniform pattern where every byte erases after one pulse checks the plain address walk and the final restore write.
- A mixed pattern of per-byte needs separates resuming at the current address from restarting at zero, because a restart would verify extra addresses and the expected cycle trace would no longer match.
- A byte needing exactly `MAX_PULSES` pulses, and another needing one more, fall on either side of the limit and separate a correct count from an off-by-one.
- A stray `start` during a run, and a restart after an error, check that the end states hold and that a new run clears both counters.

// File: rtl/ces_pkg.sv
package ces_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PREP,
        S_SETUP,
        S_CONFIRM,
        S_PWAIT,
        S_VCMD,
        S_VWAIT,
        S_VREAD,
        S_VCMP,
        S_RESTORE,
        S_DONE,
        S_FAIL
    } ces_state_e;

    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_VERIFY  = 8'hA0;
    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] BYTE_ERASED = 8'hFF;

endpackage

// File: rtl/ces_wait_timer.sv
// Down counter for the settle waits; expired is high while the count is zero.
module ces_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ces_progress.sv
// Address under test and run-wide failed-pulse counter.
module ces_progress #(
    parameter int ADDR_W     = 18,
    parameter int MAX_PULSES = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              addr_next,
    input  logic              pulse_fail,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic              fail_last
);

    localparam int PC_W = $clog2(MAX_PULSES + 1);
    localparam logic [PC_W-1:0] FAIL_LIMIT_M1 = PC_W'(MAX_PULSES - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [PC_W-1:0]   fails_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clear) begin
            addr_q <= '0;
        end else if (addr_next) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fails_q <= '0;
        end else if (clear) begin
            fails_q <= '0;
        end else if (pulse_fail) begin
            fails_q <= fails_q + 1'b1;
        end
    end

    assign addr      = addr_q;
    assign addr_last = (addr_q == {ADDR_W{1'b1}});
    assign fail_last = (fails_q == FAIL_LIMIT_M1);

endmodule

// File: rtl/ces_fsm.sv
module ces_fsm
    import ces_pkg::*;
#(
    parameter int PULSE_WAIT  = 2000000,
    parameter int VERIFY_WAIT = 1200,
    parameter int CNT_W       = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pre_ack,
    input  logic             timer_expired,
    input  logic             byte_erased,
    input  logic             addr_last,
    input  logic             fail_last,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             prog_clear,
    output logic             addr_next,
    output logic             pulse_fail,
    output logic             pre_req,
    output logic             bus_we,
    output logic             bus_re,
    output logic [7:0]       bus_wdata,
    output logic             done,
    output logic             error
);

    localparam logic [CNT_W-1:0] PW_LOAD = CNT_W'(PULSE_WAIT - 1);
    localparam logic [CNT_W-1:0] VW_LOAD = CNT_W'(VERIFY_WAIT - 1);

    ces_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath strobes
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = PW_LOAD;
        prog_clear = 1'b0;
        addr_next  = 1'b0;
        pulse_fail = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) state_d = S_PREP;
            end
            S_PREP: begin
                if (pre_ack) begin
                    state_d    = S_SETUP;
                    prog_clear = 1'b1;
                end
            end
            S_SETUP: state_d = S_CONFIRM;
            S_CONFIRM: begin
                state_d    = S_PWAIT;
                timer_load = 1'b1;
                timer_val  = PW_LOAD;
            end
            S_PWAIT: begin
                if (timer_expired) state_d = S_VCMD;
            end
            S_VCMD: begin
                state_d    = S_VWAIT;
                timer_load = 1'b1;
                timer_val  = VW_LOAD;
            end
            S_VWAIT: begin
                if (timer_expired) state_d = S_VREAD;
            end
            S_VREAD: state_d = S_VCMP;
            S_VCMP: begin
                if (byte_erased) begin
                    if (addr_last) begin
                        state_d = S_RESTORE;
                    end else begin
                        state_d   = S_VCMD;
                        addr_next = 1'b1;
                    end
                end else if (fail_last) begin
                    state_d = S_FAIL;
                end else begin
                    state_d    = S_SETUP;
                    pulse_fail = 1'b1;
                end
            end
            S_RESTORE: state_d = S_DONE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        pre_req   = 1'b0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_wdata = CMD_READ;
        done      = 1'b0;
        error     = 1'b0;
        unique case (state_q)
            S_PREP: pre_req = 1'b1;
            S_SETUP, S_CONFIRM: begin
                bus_we    = 1'b1;
                bus_wdata = CMD_ERASE;
            end
            S_VCMD: begin
                bus_we    = 1'b1;
                bus_wdata = CMD_VERIFY;
            end
            S_VREAD: bus_re = 1'b1;
            S_RESTORE: begin
                bus_we    = 1'b1;
                bus_wdata = CMD_READ;
            end
            S_DONE: done  = 1'b1;
            S_FAIL: error = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
    import ces_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int PULSE_WAIT  = 2000000,
    parameter int VERIFY_WAIT = 1200,
    parameter int MAX_PULSES  = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              pre_req,
    input  logic              pre_ack,
    output logic              bus_we,
    output logic              bus_re,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              done,
    output logic              error
);

    localparam int WAIT_MAX = (PULSE_WAIT > VERIFY_WAIT) ? PULSE_WAIT : VERIFY_WAIT;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_expired;
    logic             prog_clear;
    logic             addr_next;
    logic             pulse_fail;
    logic             addr_last;
    logic             fail_last;
    logic             byte_erased;

    assign byte_erased = (bus_rdata == BYTE_ERASED);

    ces_fsm #(
        .PULSE_WAIT (PULSE_WAIT),
        .VERIFY_WAIT(VERIFY_WAIT),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .pre_ack      (pre_ack),
        .timer_expired(timer_expired),
        .byte_erased  (byte_erased),
        .addr_last    (addr_last),
        .fail_last    (fail_last),
        .timer_load   (timer_load),
        .timer_val    (timer_val),
        .prog_clear   (prog_clear),
        .addr_next    (addr_next),
        .pulse_fail   (pulse_fail),
        .pre_req      (pre_req),
        .bus_we       (bus_we),
        .bus_re       (bus_re),
        .bus_wdata    (bus_wdata),
        .done         (done),
        .error        (error)
    );

    ces_wait_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .load_val(timer_val),
        .expired (timer_expired)
    );

    ces_progress #(
        .ADDR_W    (ADDR_W),
        .MAX_PULSES(MAX_PULSES)
    ) u_progress (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (prog_clear),
        .addr_next (addr_next),
        .pulse_fail(pulse_fail),
        .addr      (bus_addr),
        .addr_last (addr_last),
        .fail_last (fail_last)
    );

endmodule

// File: rtl/ces_checker.sv
module ces_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       pre_req,
    input logic       bus_we,
    input logic       bus_re,
    input logic [7:0] bus_wdata,
    input logic       done,
    input logic       error
);

    a_r2_no_bus_while_prep: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> (!bus_we && !bus_re));

    a_r3_erase_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata == 8'h20 && !$past(bus_we && bus_wdata == 8'h20))
        |=> (bus_we && bus_wdata == 8'h20));

    a_r3_quiet_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata == 8'h20 && $past(bus_we && bus_wdata == 8'h20))
        |=> (!bus_we && !bus_re));

    a_r4_compare_cycle_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> (!bus_we && !bus_re));

    a_r8_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!bus_we && !bus_re && !pre_req));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_we, bus_re, pre_req, done, error}));

    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r10_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

endmodule

bind chip_erase_seq ces_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pre_req  (pre_req),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_wdata(bus_wdata),
    .done     (done),
    .error    (error)
);

// File: tb/chip_erase_seq_bench.sv
`timescale 1ns/100ps
module chip_erase_seq_bench;

    localparam int AW      = 3;
    localparam int NB      = 1 << AW;
    localparam int PW      = 5;
    localparam int VW      = 3;
    localparam int MP      = 4;
    localparam int ACK_DLY = 3;
    localparam int WDOG    = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pre_ack = 1'b0;
    logic [7:0]    bus_rdata = 8'h00;
    logic          pre_req, bus_we, bus_re, done, error;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;

    always #2.5 clk = ~clk;

    chip_erase_seq #(
        .ADDR_W(AW), .PULSE_WAIT(PW), .VERIFY_WAIT(VW), .MAX_PULSES(MP)
    ) u_chip_erase_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pre_req(pre_req),
        .pre_ack(pre_ack), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .error(error)
    );

    typedef struct {
        bit    req, we, re, dn, er;
        int    addr;
        int    wdata;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t term;
    int   need[NB];
    int   vectors = 0;
    int   miscompares = 0;
    bit   cmp_on = 1'b0;
    int   flash_pulses = 0;
    int   req_cnt = 0;
    bit   prev_e20 = 1'b0;
    int   cyc = 0;

    function automatic exp_t mk(bit req, bit we, bit re, int a, int wd, string tag);
        exp_t e;
        e.req = req; e.we = we; e.re = re; e.dn = 1'b0; e.er = 1'b0;
        e.addr = a; e.wdata = wd; e.tag = tag;
        return e;
    endfunction

    // Behavioural reference: per-cycle expected outputs of one run
    function automatic void build();
        int a = 0;
        int fails = 0;
        int pulses = 0;
        bit first = 1'b1;
        q.delete();
        for (int i = 0; i < ACK_DLY; i++) q.push_back(mk(1, 0, 0, 0, 0, "R2"));
        forever begin
            q.push_back(mk(0, 1, 0, a, 8'h20, first ? "R5" : "R7"));
            q.push_back(mk(0, 1, 0, a, 8'h20, "R3"));
            for (int i = 0; i < PW; i++) q.push_back(mk(0, 0, 0, a, 0, "R3"));
            pulses++;
            first = 1'b0;
            forever begin
                q.push_back(mk(0, 1, 0, a, 8'hA0, "R4"));
                for (int i = 0; i < VW; i++) q.push_back(mk(0, 0, 0, a, 0, "R4"));
                q.push_back(mk(0, 0, 1, a, 0, "R4"));
                q.push_back(mk(0, 0, 0, a, 0, "R4"));
                if (pulses >= need[a]) begin
                    if (a == NB - 1) begin
                        q.push_back(mk(0, 1, 0, a, 8'h00, "R9"));
                        term = mk(0, 0, 0, a, 0, "R10");
                        term.dn = 1'b1;
                        return;
                    end
                    a++;
                    q[q.size()-1].tag = "R6";
                end else begin
                    fails++;
                    if (fails == MP) begin
                        term = mk(0, 0, 0, a, 0, "R8");
                        term.er = 1'b1;
                        return;
                    end
                    break;
                end
            end
        end
    endfunction

    task automatic check1(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, then act as the flash device and the pre-program agent
    always @(negedge clk) begin
        if (cmp_on) begin
            exp_t e;
            bit bad;
            if (q.size() > 0) e = q.pop_front(); else e = term;
            bad = (pre_req != e.req) || (bus_we != e.we) || (bus_re != e.re) ||
                  (done != e.dn) || (error != e.er) ||
                  ((e.we || e.re) && (int'(bus_addr) != e.addr)) ||
                  (e.we && (int'(bus_wdata) != e.wdata));
            vectors++;
            if (bad) begin
                miscompares++;
                $display("FAIL %s actual={req%0b we%0b re%0b a%0h d%0h dn%0b er%0b} expected={req%0b we%0b re%0b a%0h d%0h dn%0b er%0b}",
                         e.tag, pre_req, bus_we, bus_re, bus_addr, bus_wdata, done, error,
                         e.req, e.we, e.re, e.addr, e.wdata, e.dn, e.er);
            end
        end
        if (rst_n) begin
            if (pre_req) begin
                req_cnt++;
                if (req_cnt == ACK_DLY) begin
                    pre_ack = 1'b1;
                    flash_pulses = 0;
                    req_cnt = 0;
                end else begin
                    pre_ack = 1'b0;
                end
            end else begin
                pre_ack = 1'b0;
                req_cnt = 0;
            end
            if (bus_we && bus_wdata == 8'h20) begin
                if (prev_e20) flash_pulses++;
                prev_e20 = 1'b1;
            end else if (bus_we) begin
                prev_e20 = 1'b0;
            end
            if (bus_re) bus_rdata = (flash_pulses >= need[bus_addr]) ? 8'hFF : 8'h3C;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic run(int stray_at);
        build();
        @(negedge clk); #1;
        start = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (stray_at > 0) begin
            // R10: a start pulse in the middle of a run must change nothing
            repeat (stray_at) @(negedge clk);
            #1 start = 1'b1;
            @(negedge clk); #1 start = 1'b0;
        end
        wait (q.size() == 0);
        repeat (4) @(negedge clk);
        #1 cmp_on = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) need[i] = 1;
        repeat (3) begin
            @(negedge clk);
            check1("R1", "outputs in reset", int'({pre_req, bus_we, bus_re, done, error}), 0);
        end
        #1 rst_n = 1'b1;
        @(negedge clk);
        check1("R1", "outputs after reset", int'({pre_req, bus_we, bus_re, done, error}), 0);

        // R5 R6 R9: every byte erases after one pulse
        run(0);

        // R7: mixed needs, verification resumes at the failing address
        need = '{1, 2, 2, 3, 1, 1, 3, 2};
        run(0);

        // R8 boundary: the last byte needs exactly MP pulses, still done
        for (int i = 0; i < NB; i++) need[i] = 1;
        need[NB-1] = MP;
        run(0);

        // R8: one byte needs one pulse more than the limit
        for (int i = 0; i < NB; i++) need[i] = 1;
        need[2] = MP + 1;
        run(0);

        // R10: restart from the error state with a stray start mid-run
        for (int i = 0; i < NB; i++) need[i] = 1;
        run(15);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule